// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block resolves a guest virtual address to a host physical address after a translation-cache miss in a virtualized memory system. The translation happens in two dimensions. The guest's own four-level tables map the guest virtual address to a guest physical address. The hypervisor's four-level nested tables map every guest physical address to a host physical address. Before the walker reads any guest table, it resolves the address of that table through a complete nested walk. It does the same for the guest root and for the final guest physical address.

A request carries the guest virtual address and the access kind (read, write or execute). The guest root is a guest physical address and the nested root is a host physical address. Table entries are fetched through one memory read port, and only one read is in flight at a time. When a walk ends, the block gives a one-cycle completion. It carries either the host physical address with the combined rights, or a fault record. The fault record gives the fault kind, the level at which the fault happened and the guest physical address involved. Every completion also reports how many table reads the walk used.

Entries are 64 bits wide. The walker uses these fields:
- bit 0: present
- bit 1: writable
- bit 7: large leaf
- bit 63: no-execute
- bits 51:12: the next frame

Top module: `nested_walker`

## Requirements
- R1: After reset the walker accepts requests (req_ready=1) and drives no memory request and no completion.
- R2: A walk with 4 KiB pages in both dimensions succeeds with exactly 24 table reads: a full 4-read nested walk before each of the 4 guest table reads, plus one for the final guest physical address.
- R3: Level n (4 = root, 1 = leaf) is indexed by address bits [12+9(n-1) +: 9], and each entry sits at table base + 8 × index. A leaf at level n keeps the low 12+9(n-1) address bits and takes the rest from entry bits 51:12. The reported guest and host physical addresses follow this rule.
- R4: On success the reported rights are {execute, write, read}. Read is always 1. Write is the AND of the writable bits (bit 1) along both walks. Execute is the AND of the inverted bit 63 along both walks.
- R5: A guest entry with bit 0 clear ends the walk with a guest fault (done_nested=0). The completion reports that level, the guest physical address of the entry, and no further reads.
- R6: When the guest rights deny a write or an execute, the walker reports a guest fault at the guest leaf level and performs no final nested walk. This holds even when the nested entry would also deny the access.
- R7: A nested entry with bit 0 clear ends the walk with a nested violation (done_nested=1). The completion reports that nested level and the guest physical address being translated, and the walker issues no further reads.
- R8: When the guest allows a write or an execute but the nested rights for the final guest physical address deny it, the walker reports a nested violation at the nested leaf level.
- R9: A guest entry with bit 7 set at level 3 or 2 is a leaf. The guest walk ends there, and the nested walks for the skipped lower levels are not performed.
- R10: A nested entry with bit 7 set at level 3 or 2 is a leaf. That nested walk ends with 5-n reads.
- R11: No memory request is driven while a read is outstanding. A request that is not yet accepted keeps its valid and its address unchanged.
- R12: done_valid is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_gva | input | VA_W | Guest virtual address |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| guest_root | input | PA_W | Guest root table, as a guest physical address |
| nest_root | input | PA_W | Nested root table, as a host physical address |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Host physical address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry read |
| done_valid | output | 1 | Completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_nested | output | 1 | Fault came from the nested dimension |
| done_level | output | 3 | Level of the fault (1 to 4) |
| done_gpa | output | PA_W | Final guest physical address, or the address involved in the fault |
| done_hpa | output | PA_W | Host physical address on success |
| done_perm | output | 3 | Combined rights {execute, write, read} |
| done_reads | output | 5 | Table reads used by this walk |

## Verification
The bench serves memory from arithmetic table layouts. It sweeps three things together:
- guest leaf depth: level 1, level 2 or level 3
- nested leaf depth: level 1, level 2 or level 3
- access kind: read, write or execute

Read counts of 24, 19, 14 and the like separate early guest termination from early nested termination. Fault injection covers three cases: guest not-present at each level, guest rights cleared at each level, and nested not-present at each level. Nested faults are injected separately on the tables that serve guest-table addresses and on those that serve data addresses, so a failure early in the walk is told apart from a failure in the final walk. A case where both the guest and the nested rights deny a write shows whether the guest fault takes priority. A memory port that stalls every fifth cycle exposes any request that changes or repeats while a read is pending.

// File: rtl/nested_walker.sv
module nested_walker #(
  parameter int VA_W = 48,
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_gva,
  input  logic            req_write,
  input  logic            req_exec,
  input  logic [PA_W-1:0] guest_root,
  input  logic [PA_W-1:0] nest_root,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done_valid,
  output logic            done_fault,
  output logic            done_nested,
  output logic [2:0]      done_level,
  output logic [PA_W-1:0] done_gpa,
  output logic [PA_W-1:0] done_hpa,
  output logic [2:0]      done_perm,
  output logic [4:0]      done_reads
);

  typedef enum logic [1:0] {IDLE, NWALK, GREAD} st_t;

  st_t             st;
  logic            pend, wr_q, ex_q, last_q;
  logic            gw, gx, nw, nx;
  logic [2:0]      glvl, nlvl;
  logic [4:0]      reads;
  logic [VA_W-1:0] gva_q;
  logic [PA_W-1:0] nroot_q, nbase, gtab, cur_gpa;

  function automatic logic [PA_W-1:0] lowmask(input logic [2:0] l);
    return ~({PA_W{1'b1}} << (12 + 9 * (int'(l) - 1)));
  endfunction

  function automatic logic [8:0] vidx(input logic [PA_W-1:0] a, input logic [2:0] l);
    logic [PA_W-1:0] s;
    s = a >> (12 + 9 * (int'(l) - 1));
    return s[8:0];
  endfunction

  logic [PA_W-1:0] gva_x, frame, hpa_n, gpa_n, gent_gpa;
  logic            nleaf, gleaf, nw_n, nx_n, gw_n, gx_n, rsp;
  logic            unused_rsp_bits;

  assign gva_x    = {{(PA_W-VA_W){1'b0}}, gva_q};
  assign frame    = {mem_rsp_data[PA_W-1:12], 12'b0};
  assign hpa_n    = (frame & ~lowmask(nlvl)) | (cur_gpa & lowmask(nlvl));
  assign gpa_n    = (frame & ~lowmask(glvl)) | (gva_x & lowmask(glvl));
  assign gent_gpa = {cur_gpa[PA_W-1:12], vidx(gva_x, glvl), 3'b0};
  assign nleaf    = (nlvl == 3'd1) || (mem_rsp_data[7] && (nlvl == 3'd2 || nlvl == 3'd3));
  assign gleaf    = (glvl == 3'd1) || (mem_rsp_data[7] && (glvl == 3'd2 || glvl == 3'd3));
  assign nw_n     = nw & mem_rsp_data[1];
  assign nx_n     = nx & ~mem_rsp_data[63];
  assign gw_n     = gw & mem_rsp_data[1];
  assign gx_n     = gx & ~mem_rsp_data[63];
  assign rsp      = mem_rsp_valid && pend;
  assign unused_rsp_bits = ^{mem_rsp_data[62:PA_W], mem_rsp_data[11:8], mem_rsp_data[6:2]};

  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st != IDLE) && !pend;
  assign mem_req_addr  = (st == NWALK) ? {nbase[PA_W-1:12], vidx(cur_gpa, nlvl), 3'b0}
                                       : {gtab[PA_W-1:12], vidx(gva_x, glvl), 3'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; pend <= 1'b0; wr_q <= 1'b0; ex_q <= 1'b0; last_q <= 1'b0;
      gw <= 1'b1; gx <= 1'b1; nw <= 1'b1; nx <= 1'b1;
      glvl <= 3'd4; nlvl <= 3'd4; reads <= '0;
      gva_q <= '0; nroot_q <= '0; nbase <= '0; gtab <= '0; cur_gpa <= '0;
      done_valid <= 1'b0; done_fault <= 1'b0; done_nested <= 1'b0; done_level <= '0;
      done_gpa <= '0; done_hpa <= '0; done_perm <= '0; done_reads <= '0;
    end else begin
      done_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) pend <= 1'b1;
      case (st)
        IDLE: if (req_valid) begin
          gva_q <= req_gva; wr_q <= req_write; ex_q <= req_exec;
          nroot_q <= nest_root; nbase <= nest_root; cur_gpa <= guest_root;
          glvl <= 3'd4; nlvl <= 3'd4; last_q <= 1'b0; reads <= '0;
          gw <= 1'b1; gx <= 1'b1; nw <= 1'b1; nx <= 1'b1;
          st <= NWALK;
        end
        NWALK: if (rsp) begin
          pend <= 1'b0;
          reads <= reads + 5'd1;
          if (!mem_rsp_data[0] || (nleaf && last_q && ((wr_q && !nw_n) || (ex_q && !nx_n)))) begin
            st <= IDLE; done_valid <= 1'b1; done_fault <= 1'b1; done_nested <= 1'b1;
            done_level <= nlvl; done_gpa <= cur_gpa; done_hpa <= '0; done_perm <= '0;
            done_reads <= reads + 5'd1;
          end else if (nleaf && last_q) begin
            st <= IDLE; done_valid <= 1'b1; done_fault <= 1'b0; done_nested <= 1'b0;
            done_level <= '0; done_gpa <= cur_gpa; done_hpa <= hpa_n;
            done_perm <= {gx & nx_n, gw & nw_n, 1'b1}; done_reads <= reads + 5'd1;
          end else if (nleaf) begin
            gtab <= hpa_n; st <= GREAD;
          end else begin
            nbase <= frame; nlvl <= nlvl - 3'd1; nw <= nw_n; nx <= nx_n;
          end
        end
        GREAD: if (rsp) begin
          pend <= 1'b0;
          reads <= reads + 5'd1;
          if (!mem_rsp_data[0] || (gleaf && ((wr_q && !gw_n) || (ex_q && !gx_n)))) begin
            st <= IDLE; done_valid <= 1'b1; done_fault <= 1'b1; done_nested <= 1'b0;
            done_level <= glvl; done_gpa <= gent_gpa; done_hpa <= '0; done_perm <= '0;
            done_reads <= reads + 5'd1;
          end else begin
            gw <= gw_n; gx <= gx_n;
            nlvl <= 3'd4; nbase <= nroot_q; nw <= 1'b1; nx <= 1'b1;
            st <= NWALK;
            if (gleaf) begin
              cur_gpa <= gpa_n; last_q <= 1'b1;
            end else begin
              cur_gpa <= frame; glvl <= glvl - 3'd1;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_read_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_reads <= 5'd24);
  assert_no_second_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  assert_write_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_fault && wr_q |-> done_perm[1]);
  assert_fault_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_level >= 3'd1 && done_level <= 3'd4);

endmodule

// File: tb/tb_nested_walker.sv
module tb_nested_walker;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_exec = 1'b0;
  logic [47:0] req_gva = '0;
  logic [51:0] guest_root, nest_root;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        req_ready, mem_req_valid, done_valid, done_fault, done_nested;
  logic [51:0] mem_req_addr, done_gpa, done_hpa;
  logic [2:0]  done_level, done_perm;
  logic [4:0]  done_reads;

  int checks = 0, fails = 0;
  bit finished = 0;
  int g_np, g_ro, g_xd, g_lg, n_np_lvl, n_np_set, n_ro, n_xd, n_lg;

  always #2.5 clk = ~clk;

  assign guest_root = 52'd4 << 12;
  assign nest_root  = (52'hA << 40) | (52'd4 << 20);

  nested_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_gva(req_gva), .req_write(req_write), .req_exec(req_exec),
    .guest_root(guest_root), .nest_root(nest_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_nested(done_nested),
    .done_level(done_level), .done_gpa(done_gpa), .done_hpa(done_hpa),
    .done_perm(done_perm), .done_reads(done_reads));

  function automatic int shf(input int l);
    return 12 + 9 * (l - 1);
  endfunction

  function automatic logic [51:0] msk(input int sh);
    return (52'd1 << sh) - 52'd1;
  endfunction

  function automatic int gidx(input logic [51:0] a, input int l);
    return int'((a >> shf(l)) & 52'h1FF);
  endfunction

  function automatic logic [63:0] mem_entry(input logic [51:0] a);
    logic [63:0] e;
    logic [51:0] fr;
    int l, idx, es;
    e = '0;
    idx = int'(a[11:3]);
    if (a[47:44] == 4'hC) begin
      l = int'(a[20:12]);
      if (l == g_np) return '0;
      e[0] = 1'b1; e[1] = (l != g_ro); e[63] = (l == g_xd);
      if (l == 1 || l == g_lg) begin
        e[7] = (l != 1);
        fr = (52'd1 << 39) | (52'(idx) << shf(l));
      end else fr = 52'(l - 1) << 12;
    end else begin
      l = int'(a[23:20]);
      es = (l == 4) ? (idx & 1) : int'(a[24]);
      if (l == n_np_lvl && es == n_np_set) return '0;
      e[0] = 1'b1;
      e[1] = !(n_ro != 0 && es == 1 && l == 4);
      e[63] = (n_xd != 0 && es == 1 && l == 4);
      if (l == 1 || l == n_lg) begin
        e[7] = (l != 1);
        fr = (52'hC << 44) | (52'(es) << 43) | (52'(l) << 40) | (52'(idx) << shf(l));
      end else fr = (52'hA << 40) | (52'(es) << 24) | (52'(l - 1) << 20);
    end
    e[51:12] = fr[51:12];
    return e;
  endfunction

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory responder: single outstanding read, stalls ready every fifth cycle
  initial begin
    bit pend_tb = 0, prev_hold = 0;
    logic [51:0] addr_tb = '0, prev_addr = '0;
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (rst_n) begin
        if (prev_hold) begin
          check_eq("R11 held valid", 64'(mem_req_valid), 64'd1);
          check_eq("R11 held addr", 64'(mem_req_addr), 64'(prev_addr));
        end
        if (pend_tb) begin
          if (mem_req_valid) check_eq("R11 request while outstanding", 64'(mem_req_valid), 64'd0);
          mem_rsp_valid = 1'b1;
          mem_rsp_data = mem_entry(addr_tb);
          pend_tb = 0;
          mem_req_ready = 1'b0;
          prev_hold = 0;
        end else begin
          mem_req_ready = (cyc % 5 != 0);
          if (mem_req_ready && mem_req_valid) begin
            pend_tb = 1;
            addr_tb = mem_req_addr;
          end
          prev_hold = mem_req_valid && !mem_req_ready;
          prev_addr = mem_req_addr;
        end
      end
    end
  end

  task automatic run_walk(input logic [51:0] gva, input bit wr, input bit ex);
    int lf, nlen, lge, step, base, cnt;
    bit gf, gw, gx, nw, nx, e_fault, e_nest, e_ok;
    int e_lvl, e_reads;
    logic [51:0] e_gpa, e_hpa, fg;
    logic [2:0] e_perm;
    string tag;
    lf = (n_lg != 0) ? n_lg : 1;
    nlen = 5 - lf;
    lge = (g_lg != 0) ? g_lg : 1;
    step = nlen + 1;
    e_fault = 0; e_nest = 0; e_lvl = 0; e_reads = 0; e_gpa = '0; e_hpa = '0; e_perm = '0;
    e_ok = 0; tag = "";
    if (n_np_lvl != 0 && n_np_set == 0 && n_np_lvl >= lf) begin
      e_fault = 1; e_nest = 1; e_lvl = n_np_lvl; e_reads = 5 - n_np_lvl;
      e_gpa = 52'd4 << 12; tag = "R7 table";
    end else begin
      gf = 0;
      for (int l = 4; l >= lge; l--)
        if (!gf && l == g_np) begin
          gf = 1; e_fault = 1; e_lvl = l; e_reads = (5 - l) * step;
          e_gpa = (52'(l) << 12) | (52'(gidx(gva, l)) << 3); tag = "R5";
        end
      if (!gf) begin
        gw = !(g_ro != 0 && g_ro >= lge);
        gx = !(g_xd != 0 && g_xd >= lge);
        base = (5 - lge) * step;
        if ((wr && !gw) || (ex && !gx)) begin
          e_fault = 1; e_lvl = lge; e_reads = base;
          e_gpa = (52'(lge) << 12) | (52'(gidx(gva, lge)) << 3); tag = "R6";
        end else begin
          fg = (52'd1 << 39) | (52'(gidx(gva, lge)) << shf(lge)) | (gva & msk(shf(lge)));
          e_gpa = fg;
          nw = (n_ro == 0); nx = (n_xd == 0);
          if (n_np_lvl != 0 && n_np_set == 1 && n_np_lvl >= lf) begin
            e_fault = 1; e_nest = 1; e_lvl = n_np_lvl; e_reads = base + 5 - n_np_lvl; tag = "R7 data";
          end else if ((wr && !nw) || (ex && !nx)) begin
            e_fault = 1; e_nest = 1; e_lvl = lf; e_reads = base + nlen; tag = "R8";
          end else begin
            e_ok = 1; e_reads = base + nlen;
            e_hpa = (52'hC << 44) | (52'd1 << 43) | (52'(lf) << 40)
                  | (52'(gidx(fg, lf)) << shf(lf)) | (fg & msk(shf(lf)));
            e_perm = {gx && nx, gw && nw, 1'b1};
            tag = "R2";
            if (g_lg != 0) tag = {tag, " R9"};
            if (n_lg != 0) tag = {tag, " R10"};
          end
        end
      end
    end

    @(negedge clk);
    req_gva = gva[47:0]; req_write = wr; req_exec = ex; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (!done_valid && cnt < 3000) begin @(negedge clk); cnt++; end
    if (!done_valid) begin
      check_eq({tag, " completion timeout"}, 64'd0, 64'd1);
      return;
    end
    check_eq({tag, " fault"}, 64'(done_fault), 64'(e_fault));
    check_eq({tag, " reads"}, 64'(done_reads), 64'(e_reads));
    check_eq({tag, " R3 gpa"}, 64'(done_gpa), 64'(e_gpa));
    if (e_fault) begin
      check_eq({tag, " dimension"}, 64'(done_nested), 64'(e_nest));
      check_eq({tag, " level"}, 64'(done_level), 64'(e_lvl));
    end
    if (e_ok) begin
      check_eq({tag, " R3 hpa"}, 64'(done_hpa), 64'(e_hpa));
      check_eq({tag, " R4 perm"}, 64'(done_perm), 64'(e_perm));
    end
    @(negedge clk);
    check_eq("R12 done pulse width", 64'(done_valid), 64'd0);
  endtask

  task automatic set_scenario(input int sc);
    g_np = 0; g_ro = 0; g_xd = 0; n_np_lvl = 0; n_np_set = 0; n_ro = 0; n_xd = 0;
    if (sc >= 1 && sc <= 4) g_np = sc;
    else if (sc >= 5 && sc <= 8) g_ro = sc - 4;
    else if (sc >= 9 && sc <= 12) g_xd = sc - 8;
    else if (sc >= 13 && sc <= 16) begin n_np_lvl = sc - 12; n_np_set = 0; end
    else if (sc >= 17 && sc <= 20) begin n_np_lvl = sc - 16; n_np_set = 1; end
    else if (sc == 21) n_ro = 1;
    else if (sc == 22) n_xd = 1;
    else if (sc == 23) begin g_ro = 1; g_xd = 1; n_ro = 1; n_xd = 1; end
  endtask

  initial begin
    int k;
    logic [51:0] gva;
    g_lg = 0; n_lg = 0;
    set_scenario(0);
    repeat (4) @(negedge clk);
    check_eq("R1 ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 ready", 64'(req_ready), 64'd1);
    check_eq("R1 no memory request", 64'(mem_req_valid), 64'd0);
    check_eq("R1 no completion", 64'(done_valid), 64'd0);
    k = 0;
    for (int gl = 0; gl < 3; gl++)
      for (int nl = 0; nl < 3; nl++)
        for (int sc = 0; sc < 24; sc++)
          for (int acc = 0; acc < 3; acc++) begin
            g_lg = (gl == 0) ? 0 : gl + 1;
            n_lg = (nl == 0) ? 0 : nl + 1;
            set_scenario(sc);
            k++;
            gva = {4'h0, 9'(k * 37 + 1), 9'(k * 91 + 2), 9'(k * 13 + 3), 9'(k * 201 + 4), 12'(k * 1445)};
            run_walk(gva, acc == 1, acc == 2);
          end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule